// File: doc/BRIEF.md
# Condition-Code ALU with Branch Decision

This block is the execute stage of a small 32-bit load/store processor. It performs AND, OR, NOR, logical right shift, addition and the upper-constant load on a first register operand and a second operand. The second operand is either a second register or a sign-extended 13-bit immediate. The result goes into an output register. The operations that set flags also update a held four-bit condition-code register with negative, zero, overflow and carry bits.

A separate branch path tests the held condition codes against one of five branch conditions and registers a taken decision. Decode supplies the operation, the operand-select bit, the two immediates and the strobes. The register file, fetch and memory access lie outside the block.

Top module: `cc_alu`

## Requirements
- R1: A synchronous active-high reset clears result_o to 0, flags_o to 0 and taken_o to 0.
- R2: The operation codes are 0 AND, 1 OR, 2 NOR (inverted OR) and 4 ADD. When op_valid_i is high on a rising edge, result_o shows the outcome of that operation from that edge onward.
- R3: When use_imm_i is 1, the second operand is imm13_i sign-extended from bit 12 to 32 bits. When use_imm_i is 0, the second operand is rs2_i.
- R4: Operation code 3 is a logical right shift of rs1_i. The shift distance is bits 4:0 of the second operand, and zeros fill from the top.
- R5: For ADD, flag c is the carry out of bit 31. Flag v is set when both operands have the same sign and the sum has the opposite sign.
- R6: Operation code 5 loads imm22_i into result bits 31:10 and clears bits 9:0. It leaves flags_o unchanged.
- R7: flags_o is {n, z, v, c} from bit 3 down to bit 0. After operation codes 0 to 4, n equals result bit 31 and z is set exactly when the result is zero. Operation codes 0 to 3 clear c and v.
- R8: If op_valid_i is low, or the operation code is 6 or 7, a rising edge leaves result_o and flags_o unchanged.
- R9: Branch select codes are 0 taken on z, 1 on n, 2 on c, 3 on v, and 4 always. At an edge where br_valid_i is high, taken_o takes the decision made from the flags held before that edge.
- R10: taken_o is 0 after an edge where br_valid_i is low or the branch select is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| use_imm_i | input | 1 | Use the immediate as the second operand |
| imm13_i | input | 13 | Signed short immediate |
| imm22_i | input | 22 | Upper constant for the upper-load operation |
| br_valid_i | input | 1 | Branch evaluation strobe |
| br_sel_i | input | 3 | Branch condition select |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Held condition codes {n,z,v,c} |
| taken_o | output | 1 | Registered branch decision |

## Verification
Assertions check on every cycle that idle or undefined operations hold the result and flags. They also check that n and z agree with the registered result after every flag-setting operation, and that logic and shift operations leave c and v clear. Further cycle-by-cycle checks cover the upper-load: bits 9:0 are clear and the flags stay stable. On the branch side, the always condition is taken and no strobe means not taken. Only the bench scenarios can show the actual arithmetic values, the carry and overflow outcomes at the sign boundaries, and the sign extension and shift-amount masking. They also show that a branch issued on the same edge as a flag update sees the older flags.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_NOR   = 3'd2,
    OP_SRL   = 3'd3,
    OP_ADD   = 3'd4,
    OP_SETHI = 3'd5
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_ZERO  = 3'd0,
    BR_NEG   = 3'd1,
    BR_CARRY = 3'd2,
    BR_OVF   = 3'd3,
    BR_ALWAYS = 3'd4
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

endpackage

// File: rtl/operand_mux.sv
module operand_mux #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign opnd_o  = use_imm_i ? imm_ext : reg_i;

  always_comb begin
    if (use_imm_i)
      a_sext_r3: assert (opnd_o[DATA_W-1:IMM_W-1] == '0 || opnd_o[DATA_W-1:IMM_W-1] == '1);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HI_W   = 22
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [HI_W-1:0]   hi_i,
  input  cc_flags_t         flags_i,
  output logic [DATA_W-1:0] res_o,
  output cc_flags_t         flags_o,
  output logic              known_o,
  output logic              set_cc_o
);
  localparam int LO_W    = DATA_W - HI_W;
  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W:0]        sum_ext;
  logic [SHAMT_W-1:0]     shamt;
  logic                   add_ovf;

  assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
  assign shamt   = b_i[SHAMT_W-1:0];
  assign add_ovf = (a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                   (sum_ext[DATA_W-1] != a_i[DATA_W-1]);

  always_comb begin
    res_o    = '0;
    known_o  = 1'b1;
    set_cc_o = 1'b1;
    unique case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_NOR:   res_o = ~(a_i | b_i);
      OP_SRL:   res_o = a_i >> shamt;
      OP_ADD:   res_o = sum_ext[DATA_W-1:0];
      OP_SETHI: begin
        res_o    = {hi_i, {LO_W{1'b0}}};
        set_cc_o = 1'b0;
      end
      default: begin
        known_o  = 1'b0;
        set_cc_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    flags_o = flags_i;
    if (set_cc_o) begin
      flags_o.n = res_o[DATA_W-1];
      flags_o.z = (res_o == '0);
      flags_o.c = (op_i == OP_ADD) ? sum_ext[DATA_W] : 1'b0;
      flags_o.v = (op_i == OP_ADD) ? add_ovf : 1'b0;
    end
  end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cc_flags_t flags_i,
  input  logic      br_valid_i,
  input  logic [2:0] br_sel_i,
  output logic      taken_o
);
  logic cond;

  always_comb begin
    case (br_sel_i)
      BR_ZERO:   cond = flags_i.z;
      BR_NEG:    cond = flags_i.n;
      BR_CARRY:  cond = flags_i.c;
      BR_OVF:    cond = flags_i.v;
      BR_ALWAYS: cond = 1'b1;
      default:   cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) taken_o <= 1'b0;
    else     taken_o <= br_valid_i & cond;
  end

  p_always_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && br_sel_i == 3'd4) |=> taken_o);

  p_idle_not_taken_r10: assert property (@(posedge clk) disable iff (rst)
    (!br_valid_i || br_sel_i > 3'd4) |=> !taken_o);

  p_zero_cond_r9: assert property (@(posedge clk) disable iff (rst)
    (br_valid_i && br_sel_i == 3'd0) |=> (taken_o == $past(flags_i.z)));
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13,
  parameter int HI_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm13_i,
  input  logic [HI_W-1:0]   imm22_i,
  input  logic              br_valid_i,
  input  logic [2:0]        br_sel_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              taken_o
);
  localparam int LO_W = DATA_W - HI_W;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  cc_flags_t         flags_q;
  cc_flags_t         flags_nx;
  logic              known;
  logic              set_cc;
  logic [DATA_W-1:0] result_q;

  operand_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mux (
    .reg_i     (rs2_i),
    .imm_i     (imm13_i),
    .use_imm_i (use_imm_i),
    .opnd_o    (opnd_b)
  );

  alu_core #(.DATA_W(DATA_W), .HI_W(HI_W)) u_core (
    .op_i     (alu_op_e'(op_i)),
    .a_i      (rs1_i),
    .b_i      (opnd_b),
    .hi_i     (imm22_i),
    .flags_i  (flags_q),
    .res_o    (alu_res),
    .flags_o  (flags_nx),
    .known_o  (known),
    .set_cc_o (set_cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (op_valid_i && known) begin
      result_q <= alu_res;
      if (set_cc) flags_q <= flags_nx;
    end
  end

  branch_eval u_br (
    .clk        (clk),
    .rst        (rst),
    .flags_i    (flags_q),
    .br_valid_i (br_valid_i),
    .br_sel_i   (br_sel_i),
    .taken_o    (taken_o)
  );

  assign result_o = result_q;
  assign flags_o  = flags_q;

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!op_valid_i || op_i > 3'd5) |=> ($stable(result_o) && $stable(flags_o)));

  p_nz_track_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i <= 3'd4) |=>
      (flags_o[3] == result_o[DATA_W-1]) && (flags_o[2] == (result_o == '0)));

  p_logic_cv_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i <= 3'd3) |=> (flags_o[1:0] == 2'b00));

  p_sethi_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_i == 3'd5) |=> ($stable(flags_o) && result_o[LO_W-1:0] == '0));
endmodule

// File: tb/tb_cc_alu.sv
module tb_cc_alu;
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        imm;
    logic [12:0] i13;
    logic [21:0] i22;
    logic [31:0] res;
    logic [3:0]  fl;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd0, 32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 13'h0, 22'h0, 32'hF000F000, 4'b1000}, // R2 AND
    '{4'd2, 3'd1, 32'h000000F0, 32'h0000000F, 1'b0, 13'h0, 22'h0, 32'h000000FF, 4'b0000}, // R2 OR
    '{4'd2, 3'd2, 32'h00000000, 32'h00000000, 1'b0, 13'h0, 22'h0, 32'hFFFFFFFF, 4'b1000}, // R2 NOR
    '{4'd7, 3'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0, 13'h0, 22'h0, 32'h00000000, 4'b0100}, // R7 z on NOR
    '{4'd3, 3'd0, 32'h12345678, 32'h0, 1'b1, 13'h1FFF, 22'h0, 32'h12345678, 4'b0000},     // R3 imm -1
    '{4'd3, 3'd1, 32'h00000005, 32'h0, 1'b1, 13'h1000, 22'h0, 32'hFFFFF005, 4'b1000},     // R3 imm -4096
    '{4'd4, 3'd3, 32'h80000000, 32'h00000024, 1'b0, 13'h0, 22'h0, 32'h08000000, 4'b0000}, // R4 masked shamt
    '{4'd4, 3'd3, 32'hFFFFFFFF, 32'h0000001F, 1'b0, 13'h0, 22'h0, 32'h00000001, 4'b0000}, // R4 max shift
    '{4'd5, 3'd4, 32'hFFFFFFFF, 32'h00000001, 1'b0, 13'h0, 22'h0, 32'h00000000, 4'b0101}, // R5 carry+zero
    '{4'd5, 3'd4, 32'h7FFFFFFF, 32'h00000001, 1'b0, 13'h0, 22'h0, 32'h80000000, 4'b1010}, // R5 overflow
    '{4'd5, 3'd4, 32'h80000000, 32'h80000000, 1'b0, 13'h0, 22'h0, 32'h00000000, 4'b0111}, // R5 z v c
    '{4'd5, 3'd4, 32'h00000005, 32'h0, 1'b1, 13'h1FFD, 22'h0, 32'h00000002, 4'b0001},     // R5 add imm
    '{4'd5, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 13'h0, 22'h0, 32'hFFFFFFFE, 4'b1001}, // R5 n c
    '{4'd6, 3'd5, 32'hDEADBEEF, 32'h0, 1'b0, 13'h0, 22'h2AAAAA, 32'hAAAAA800, 4'b1001}    // R6 keeps flags
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] rs1_i = '0;
  logic [31:0] rs2_i = '0;
  logic        use_imm_i = 1'b0;
  logic [12:0] imm13_i = '0;
  logic [21:0] imm22_i = '0;
  logic        br_valid_i = 1'b0;
  logic [2:0]  br_sel_i = '0;
  logic [31:0] result_o;
  logic [3:0]  flags_o;
  logic        taken_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  cc_alu dut (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .use_imm_i(use_imm_i), .imm13_i(imm13_i),
    .imm22_i(imm22_i), .br_valid_i(br_valid_i), .br_sel_i(br_sel_i),
    .result_o(result_o), .flags_o(flags_o), .taken_o(taken_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op_step(input logic v, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic im, input logic [12:0] i13,
                         input logic [21:0] i22);
    @(negedge clk);
    op_valid_i = v; op_i = op; rs1_i = a; rs2_i = b;
    use_imm_i = im; imm13_i = i13; imm22_i = i22;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic br_step(input logic v, input logic [2:0] sel, input logic exp, input string tag);
    @(negedge clk);
    br_valid_i = v; br_sel_i = sel;
    @(negedge clk);
    br_valid_i = 1'b0;
    chk(tag, {31'd0, taken_o}, {31'd0, exp});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 result", result_o, 32'h0);
    chk("R1 flags", {28'd0, flags_o}, 32'h0);
    chk("R1 taken", {31'd0, taken_o}, 32'h0);

    // R2..R7 vector table
    for (int k = 0; k < NV; k++) begin
      op_step(1'b1, VECS[k].op, VECS[k].a, VECS[k].b, VECS[k].imm, VECS[k].i13, VECS[k].i22);
      chk($sformatf("R%0d result vec %0d", VECS[k].req, k), result_o, VECS[k].res);
      chk($sformatf("R%0d flags vec %0d", VECS[k].req, k), {28'd0, flags_o}, {28'd0, VECS[k].fl});
    end

    // R8 strobe low: nothing changes (result AAAAA800, flags 1001)
    op_step(1'b0, 3'd4, 32'h1, 32'h1, 1'b0, 13'h0, 22'h0);
    chk("R8 idle result", result_o, 32'hAAAAA800);
    chk("R8 idle flags", {28'd0, flags_o}, 32'h9);
    // R8 undefined op codes 6 and 7 with strobe high
    op_step(1'b1, 3'd6, 32'h0, 32'h0, 1'b0, 13'h0, 22'h0);
    chk("R8 op6 result", result_o, 32'hAAAAA800);
    chk("R8 op6 flags", {28'd0, flags_o}, 32'h9);
    op_step(1'b1, 3'd7, 32'h0, 32'h0, 1'b0, 13'h0, 22'h0);
    chk("R8 op7 flags", {28'd0, flags_o}, 32'h9);

    // R6 again: upper load after a z/c result keeps flags 0101
    op_step(1'b1, 3'd4, 32'hFFFFFFFF, 32'h1, 1'b0, 13'h0, 22'h0);
    op_step(1'b1, 3'd5, 32'h0, 32'h0, 1'b0, 13'h0, 22'h3FFFFF);
    chk("R6 sethi result", result_o, 32'hFFFFFC00);
    chk("R6 sethi flags", {28'd0, flags_o}, 32'h5);

    // R9 branches with flags n=0 z=1 v=0 c=1
    br_step(1'b1, 3'd0, 1'b1, "R9 be z=1");
    br_step(1'b1, 3'd1, 1'b0, "R9 bneg n=0");
    br_step(1'b1, 3'd2, 1'b1, "R9 bcs c=1");
    br_step(1'b1, 3'd3, 1'b0, "R9 bvs v=0");
    br_step(1'b1, 3'd4, 1'b1, "R9 ba");

    // R9 branch on same edge as flag update sees the old flags (z=1)
    @(negedge clk);
    op_valid_i = 1'b1; op_i = 3'd4; rs1_i = 32'h7FFFFFFF; rs2_i = 32'h1; use_imm_i = 1'b0;
    br_valid_i = 1'b1; br_sel_i = 3'd0;
    @(negedge clk);
    op_valid_i = 1'b0; br_valid_i = 1'b0;
    chk("R9 be uses old z", {31'd0, taken_o}, 32'h1);
    chk("R9 new flags", {28'd0, flags_o}, 32'hA);

    // R9 with flags n=1 z=0 v=1 c=0
    br_step(1'b1, 3'd0, 1'b0, "R9 be z=0");
    br_step(1'b1, 3'd1, 1'b1, "R9 bneg n=1");
    br_step(1'b1, 3'd2, 1'b0, "R9 bcs c=0");
    br_step(1'b1, 3'd3, 1'b1, "R9 bvs v=1");

    // R10 no strobe or undefined select
    br_step(1'b0, 3'd4, 1'b0, "R10 no strobe");
    br_step(1'b1, 3'd5, 1'b0, "R10 sel 5");
    br_step(1'b1, 3'd7, 1'b0, "R10 sel 7");

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    br_valid_i = 1'b1; br_sel_i = 3'd4;
    @(negedge clk); rst = 1'b0; br_valid_i = 1'b0;
    chk("R1 reset result", result_o, 32'h0);
    chk("R1 reset flags", {28'd0, flags_o}, 32'h0);
    chk("R1 reset taken", {31'd0, taken_o}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule